// File: doc/BRIEF.md
# Two-Port RAM with Mailbox Interrupts

This block is a small synchronous memory with two independent ports, left and right. Each port has its own enable, output enable, read/write select, address and 18-bit data. The two highest addresses can act as mailboxes between the ports. When one port writes its partner's mailbox word, an active-low interrupt toward the partner asserts. The partner then accesses that word with enable and output enable both low, which clears the interrupt.

The message stays in the RAM as an ordinary word, so either port can read or overwrite it like any other location. The right port's mailbox is the highest address, and the left port's mailbox is the address one below it. Both move with the configured address width. A mode input turns the mailbox feature off. The top two words then behave as plain storage and neither interrupt changes.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is low at a rising edge, both `l_int_n` and `r_int_n` are high after that edge.
- R2: A read (enable low, `rw_n` high) places the addressed word on that port's read data after the next rising edge. In cycles without a read, the read data holds its last value.
- R3: A write (enable low, `rw_n` low) stores the write data at the address. With enable high, nothing is stored.
- R4: When both ports write the same address in the same cycle, the right port's data is the value kept.
- R5: With `irq_en` high, a left-port write to the highest address (all ones) drives `r_int_n` low after that edge.
- R6: With `irq_en` high, a right-port write to the second-highest address (all ones except bit 0) drives `l_int_n` low after that edge.
- R7: With `irq_en` high, an access by a port to its own mailbox address with enable and output enable both low drives its interrupt high after that edge, whatever the level of `rw_n`. With output enable high, the same access leaves the interrupt unchanged.
- R8: If a flag is set and cleared in the same cycle, it ends up set (interrupt low).
- R9: With `irq_en` low, neither interrupt output changes, and the mailbox words are read and written as plain memory.
- R10: A mailbox word holds the 18-bit message that was written, and the other port reads it back unchanged.
- R11: A port that writes its own mailbox address does not assert either interrupt.
- R12: When one port reads an address in the same cycle that the other port writes it, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 1 | 1 enables the mailbox interrupts |
| l_ce_n | input | 1 | Left enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw_n | input | 1 | Left select: 1 = read, 0 = write |
| l_addr | input | AW | Left address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, registered |
| l_int_n | output | 1 | Interrupt to the left port, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw_n | input | 1 | Right select: 1 = read, 0 = write |
| r_addr | input | AW | Right address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, registered |
| r_int_n | output | 1 | Interrupt to the right port, active low |

## Verification
The hardest case to reach from the ports is a set and a clear of the same flag landing in the same edge. One port has to write the mailbox while the owning port accesses it with output enable low in that same cycle. Each bench task drives both ports in one step to produce this exact overlap. It does the same for same-address collisions and for a read that coincides with a write. A further case enables the feature and sets a flag, then clears `irq_en` before the owner accesses its mailbox. This shows that the held flag survives the clearing access.

// File: rtl/mbox_pkg.sv
// Package: shared types for the mailbox two-port RAM.
// Assumes one decode record per port, produced each cycle.
package mbox_pkg;
    localparam int DATA_W = 18;

    // Decoded per-port access for one cycle
    typedef struct packed {
        logic wr;        // store request
        logic rd;        // fetch request
        logic own_clr;   // owner access of its mailbox with output enable low
        logic peer_set;  // write to the partner's mailbox
    } port_dec_t;
endpackage

// File: rtl/mbox_port_dec.sv
// Module: mbox_port_dec
// Decodes one port's control pins into access strobes and mailbox hits.
// Assumes all controls are active low, except rw_n, where 1 means read.
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int AW = 6,
    parameter logic [AW-1:0] OWN_BOX  = '1,
    parameter logic [AW-1:0] PEER_BOX = '1
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          rw_n,
    input  logic [AW-1:0] addr,
    output port_dec_t     dec
);
    // Combinational decode of this cycle's request
    always_comb begin
        dec.wr       = !ce_n && !rw_n;
        dec.rd       = !ce_n &&  rw_n;
        dec.own_clr  = !ce_n && !oe_n && (addr == OWN_BOX);
        dec.peer_set = !ce_n && !rw_n && (addr == PEER_BOX);
    end
endmodule

// File: rtl/mbox_ram.sv
// Module: mbox_ram
// Two-port synchronous storage. Reads are registered with one cycle of
// latency. A read that meets a write in the same cycle returns the old word.
// On a same-address write collision, the right port's data is kept.
// Assumes the storage contents need no reset.
module mbox_ram #(
    parameter int AW = 6,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_we,
    input  logic          l_re,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_we,
    input  logic          r_re,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store: left is applied first, then right, so right wins a collision
    always_ff @(posedge clk) begin
        if (l_we) mem[l_addr] <= l_wdata;
        if (r_we) mem[r_addr] <= r_wdata;
    end

    // Registered read data per port, held when no read occurs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_re) l_rdata <= mem[l_addr];
            if (r_re) r_rdata <= mem[r_addr];
        end
    end

    // Read data holds when neither port reads
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_re && !r_re) |=> ($stable(l_rdata) && $stable(r_rdata))); // R2
endmodule

// File: rtl/mbox_irq_flag.sv
// Module: mbox_irq_flag
// One interrupt flag. It is set by the partner's mailbox write and cleared by
// the owner's mailbox access. Set takes priority over clear. The flag is
// frozen while the feature is disabled. Output is active low.
module mbox_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic int_n
);
    logic pending;

    // Flag state update; set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (en) begin
            if (set)      pending <= 1'b1;
            else if (clr) pending <= 1'b0;
        end
    end

    assign int_n = ~pending;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set) |=> !int_n); // R8
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr && !set) |=> int_n); // R7
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(int_n)); // R9
endmodule

// File: rtl/mbox_dpram.sv
// Module: mbox_dpram (top)
// Two-port RAM in which the top two words act as cross-port mailboxes.
// The right port's mailbox is the highest address. The left port's mailbox
// is the address one below it. Assumes a single shared clock.
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_rw_n,
    input  logic [AW-1:0]     l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_int_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_rw_n,
    input  logic [AW-1:0]     r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_int_n
);
    localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] L_BOX = {{(AW-1){1'b1}}, 1'b0};

    port_dec_t l_dec, r_dec;

    mbox_port_dec #(.AW(AW), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) u_l_dec (
        .ce_n(l_ce_n), .oe_n(l_oe_n), .rw_n(l_rw_n), .addr(l_addr), .dec(l_dec)
    );
    mbox_port_dec #(.AW(AW), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) u_r_dec (
        .ce_n(r_ce_n), .oe_n(r_oe_n), .rw_n(r_rw_n), .addr(r_addr), .dec(r_dec)
    );

    mbox_ram #(.AW(AW), .DW(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .l_we(l_dec.wr), .l_re(l_dec.rd), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_we(r_dec.wr), .r_re(r_dec.rd), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // The left flag is set by the right port and cleared by the left port
    mbox_irq_flag u_l_flag (
        .clk(clk), .rst_n(rst_n), .en(irq_en),
        .set(r_dec.peer_set), .clr(l_dec.own_clr), .int_n(l_int_n)
    );
    // The right flag is set by the left port and cleared by the right port
    mbox_irq_flag u_r_flag (
        .clk(clk), .rst_n(rst_n), .en(irq_en),
        .set(l_dec.peer_set), .clr(r_dec.own_clr), .int_n(r_int_n)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (l_int_n && r_int_n)); // R1
    AST_LEFT_RAISES_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !l_ce_n && !l_rw_n && l_addr == R_BOX) |=> !r_int_n); // R5
    AST_RIGHT_RAISES_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !r_ce_n && !r_rw_n && r_addr == L_BOX) |=> !l_int_n); // R6
endmodule

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
    localparam int  AW     = 6;
    localparam time CLK_T  = 10ns;
    localparam logic [AW-1:0] TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] TOP1 = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0, rst_n = 1'b0, irq_en = 1'b1;
    logic l_ce_n = 1, l_oe_n = 1, l_rw_n = 1, r_ce_n = 1, r_oe_n = 1, r_rw_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [17:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
    logic l_int_n, r_int_n;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_T/2) clk = ~clk;

    mbox_dpram #(.AW(AW)) u_dut (.*);

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle of stimulus on both ports; returns after the edge has taken effect
    task automatic step(input logic lce, loe, lrw, input logic [AW-1:0] la, input logic [17:0] ld,
                        input logic rce, roe, rrw, input logic [AW-1:0] ra, input logic [17:0] rd);
        l_ce_n = lce; l_oe_n = loe; l_rw_n = lrw; l_addr = la; l_wdata = ld;
        r_ce_n = rce; r_oe_n = roe; r_rw_n = rrw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        l_ce_n = 1; l_oe_n = 1; l_rw_n = 1; r_ce_n = 1; r_oe_n = 1; r_rw_n = 1;
    endtask

    task automatic idle(); step(1,1,1,'0,'0, 1,1,1,'0,'0); endtask

    task automatic t_reset();
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
        chk("R1 l_int_n", l_int_n, 1); chk("R1 r_int_n", r_int_n, 1);
    endtask

    task automatic t_basic();
        step(0,1,0,6'd5,18'h12345, 1,1,1,'0,'0);
        step(1,1,1,'0,'0, 0,1,1,6'd5,'0);
        chk("R2/R3 read back", r_rdata, 18'h12345);
        idle(); chk("R2 hold", r_rdata, 18'h12345);
        step(0,1,0,6'd6,18'h00AAA, 1,1,1,'0,'0);
        step(1,1,0,6'd6,18'h3FFFF, 1,1,1,'0,'0);
        step(0,1,1,6'd6,'0, 1,1,1,'0,'0);
        chk("R3 disabled write ignored", l_rdata, 18'h00AAA);
    endtask

    task automatic t_collide();
        step(0,1,0,6'd9,18'h11111, 0,1,0,6'd9,18'h22222);
        step(0,1,1,6'd9,'0, 1,1,1,'0,'0);
        chk("R4 right wins", l_rdata, 18'h22222);
    endtask

    task automatic t_rbw();
        step(0,1,0,6'd10,18'h0F0F0, 1,1,1,'0,'0);
        step(0,1,0,6'd10,18'h33333, 0,1,1,6'd10,'0);
        chk("R12 old data", r_rdata, 18'h0F0F0);
        step(1,1,1,'0,'0, 0,1,1,6'd10,'0);
        chk("R12 new data", r_rdata, 18'h33333);
    endtask

    task automatic t_left_to_right();
        step(0,1,0,TOP,18'h2BEEF, 1,1,1,'0,'0);
        chk("R5 r_int_n low", r_int_n, 0); chk("R5 l_int_n high", l_int_n, 1);
        step(1,1,1,'0,'0, 0,0,1,TOP,'0);
        chk("R10 message", r_rdata, 18'h2BEEF); chk("R7 r clear", r_int_n, 1);
    endtask

    task automatic t_right_to_left();
        step(1,1,1,'0,'0, 0,1,0,TOP1,18'h15A5A);
        chk("R6 l_int_n low", l_int_n, 0);
        step(0,1,1,TOP1,'0, 1,1,1,'0,'0);
        chk("R7 oe high keeps flag", l_int_n, 0); chk("R10 message", l_rdata, 18'h15A5A);
        step(0,0,0,TOP1,18'h00777, 1,1,1,'0,'0);
        chk("R7 clear with rw low", l_int_n, 1);
        step(0,1,1,TOP1,'0, 1,1,1,'0,'0);
        chk("R10 overwrite", l_rdata, 18'h00777);
    endtask

    task automatic t_own_box();
        step(0,1,0,TOP1,18'h00001, 1,1,1,'0,'0);
        chk("R11 left own box", l_int_n & r_int_n, 1);
        step(1,1,1,'0,'0, 0,1,0,TOP,18'h00002);
        chk("R11 right own box", l_int_n & r_int_n, 1);
    endtask

    task automatic t_set_wins();
        step(0,0,1,TOP1,'0, 0,1,0,TOP1,18'h0ABCD);
        chk("R8 set wins", l_int_n, 0);
        step(0,0,1,TOP1,'0, 1,1,1,'0,'0);
        chk("R7 clear after", l_int_n, 1);
    endtask

    task automatic t_disabled();
        irq_en = 0;
        step(0,1,0,TOP,18'h01234, 1,1,1,'0,'0);
        chk("R9 no set", r_int_n, 1);
        step(1,1,1,'0,'0, 0,0,1,TOP,'0);
        chk("R9 plain memory", r_rdata, 18'h01234);
        irq_en = 1;
        step(1,1,1,'0,'0, 0,1,0,TOP1,18'h00055);
        chk("R6 set before disable", l_int_n, 0);
        irq_en = 0;
        step(0,0,1,TOP1,'0, 1,1,1,'0,'0);
        chk("R9 clear frozen", l_int_n, 0);
        irq_en = 1;
        step(0,0,1,TOP1,'0, 1,1,1,'0,'0);
        chk("R7 clear re-enabled", l_int_n, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_collide();
        t_rbw();
        t_left_to_right();
        t_right_to_left();
        t_own_box();
        t_set_wins();
        t_disabled();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule